// File: doc/BRIEF.md
# Aliased General-Purpose Register File

The block holds eight 32-bit general-purpose registers. Each register can be reached as a whole word or through narrower names that overlap it. There is one write port and two independent read ports. Every port carries a 3-bit register index and a 2-bit view selector. The selector chooses the full 32 bits, the low 16 bits, the low byte (bits 7:0) or the high byte (bits 15:8). A 16-bit view is made of the high byte above the low byte, and it lies inside the 32-bit view.

A narrow write changes only the chosen field and keeps every other bit of the register. A narrow read returns the chosen field in the low bits of the result, with zeros above it. Only the first four registers have a high-byte view. If the high-byte view is used on any of the other four, the block flags an error, drops the write and reads back zero.

Writes take effect on the rising clock edge. Reads are combinational, so a read in the same cycle as a write to that register still sees the old contents.

Top module: `gpr_alias_file`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all eight registers to zero.
- R2: A write with view code 0 (32-bit) stores all 32 data bits. A read with view code 0 returns the whole register.
- R3: A write with view code 1 (low 16) replaces bits 15:0 with data bits 15:0. Bits 31:16 are kept.
- R4: A write with view code 2 (low byte) replaces bits 7:0 with data bits 7:0. Bits 31:8 are kept.
- R5: A write with view code 3 (high byte) to index 0 to 3 replaces bits 15:8 with data bits 7:0. All other bits are kept.
- R6: Narrow reads are zero-extended. View 1 returns {16'b0, r[15:0]}. View 2 returns {24'b0, r[7:0]}. View 3 returns {24'b0, r[15:8]}.
- R7: View 3 on index 4 to 7 is illegal. The matching error output goes high (on the write port only while wr_en is high), the write is dropped, and the read returns zero.
- R8: A write takes effect at the rising edge. A read of the same register in the same cycle shows the value from before the write.
- R9: The two read ports use their own index and view and work independently in the same cycle.
- R10: A write changes only the addressed register. With wr_en low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_view | input | 2 | Write view: 0 full, 1 low 16, 2 low byte, 3 high byte |
| wr_data | input | 32 | Write data; narrow views take the low bits |
| wr_err | output | 1 | Illegal write view |
| ra_idx | input | 3 | Read port A index |
| ra_view | input | 2 | Read port A view |
| ra_data | output | 32 | Read port A data, zero-extended |
| ra_err | output | 1 | Read port A illegal view |
| rb_idx | input | 3 | Read port B index |
| rb_view | input | 2 | Read port B view |
| rb_data | output | 32 | Read port B data, zero-extended |
| rb_err | output | 1 | Read port B illegal view |

## Verification
The bench walks a chain of overlapping writes to the same register. This chain catches a design that clears the untouched bits on a narrow write. It also catches a design that puts the high-byte data at the wrong offset, because each check reads the whole word back. It writes the high byte to an index of 4 or above, then reads back the unchanged 32-bit value and checks the error flags. A design that decoded the high-byte view for every register would corrupt the word or leave the flag low. It also reads during a write cycle to show that reads are not bypassed. It drives both read ports with different indices at once to expose shared decode.

// File: rtl/gpr_alias_file.sv
module gpr_alias_file #(
  parameter int DATA_W  = 32,
  parameter int NREG    = 8,
  parameter int HB_REGS = 4,
  localparam int IDX_W  = $clog2(NREG),
  localparam int HALF_W = DATA_W / 2,
  localparam int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_view,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_err,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [1:0]        ra_view,
  output logic [DATA_W-1:0] ra_data,
  output logic              ra_err,
  input  logic [IDX_W-1:0]  rb_idx,
  input  logic [1:0]        rb_view,
  output logic [DATA_W-1:0] rb_data,
  output logic              rb_err
);
  localparam logic [1:0] V_FULL = 2'd0, V_HALF = 2'd1, V_LOB = 2'd2, V_HIB = 2'd3;

  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]           wr_next;

  function automatic logic bad_view(input logic [IDX_W-1:0] idx, input logic [1:0] v);
    return (v == V_HIB) && (int'(idx) >= HB_REGS);
  endfunction

  function automatic logic [DATA_W-1:0] pick(input logic [DATA_W-1:0] r, input logic [1:0] v);
    logic [DATA_W-1:0] o;
    o = '0;
    case (v)
      V_FULL: o = r;
      V_HALF: o[HALF_W-1:0] = r[HALF_W-1:0];
      V_LOB:  o[BYTE_W-1:0] = r[BYTE_W-1:0];
      default: o[BYTE_W-1:0] = r[2*BYTE_W-1:BYTE_W];
    endcase
    return o;
  endfunction

  assign wr_err  = wr_en && bad_view(wr_idx, wr_view);
  assign ra_err  = bad_view(ra_idx, ra_view);
  assign rb_err  = bad_view(rb_idx, rb_view);
  assign ra_data = ra_err ? '0 : pick(regs[ra_idx], ra_view);
  assign rb_data = rb_err ? '0 : pick(regs[rb_idx], rb_view);

  always_comb begin
    wr_next = regs[wr_idx];
    case (wr_view)
      V_FULL: wr_next = wr_data;
      V_HALF: wr_next[HALF_W-1:0] = wr_data[HALF_W-1:0];
      V_LOB:  wr_next[BYTE_W-1:0] = wr_data[BYTE_W-1:0];
      default: wr_next[2*BYTE_W-1:BYTE_W] = wr_data[BYTE_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) regs <= '0;
    else if (wr_en && !wr_err) regs[wr_idx] <= wr_next;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> regs == '0);

  // R7
  bad_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> $stable(regs));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs));

  // R3
  narrow_keep_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_err && wr_view != V_FULL)
      |=> regs[$past(wr_idx)][DATA_W-1:HALF_W] == $past(regs[wr_idx][DATA_W-1:HALF_W]));

  // R7
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ra_err |-> (ra_data == '0 && ra_view == V_HIB));

  // R6
  byte_read_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (rb_view == V_LOB || rb_view == V_HIB) |-> rb_data[DATA_W-1:BYTE_W] == '0);
endmodule

// File: tb/gpr_alias_file_tb.sv
module gpr_alias_file_tb_top;
  logic clk = 0, rst = 1;
  logic wr_en = 0; logic [2:0] wr_idx = 0; logic [1:0] wr_view = 0; logic [31:0] wr_data = 0;
  logic [2:0] ra_idx = 0, rb_idx = 0; logic [1:0] ra_view = 0, rb_view = 0;
  logic [31:0] ra_data, rb_data; logic wr_err, ra_err, rb_err;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  gpr_alias_file dut_i (.clk, .rst, .wr_en, .wr_idx, .wr_view, .wr_data, .wr_err,
    .ra_idx, .ra_view, .ra_data, .ra_err, .rb_idx, .rb_view, .rb_data, .rb_err);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // fields: wr_en, wr_idx, wr_view, wr_data, rd_idx, rd_view, expected, req
  localparam logic [78:0] VEC [14] = '{
    {1'b1,3'd0,2'd0,32'h11223344, 3'd0,2'd0,32'h11223344, 4'd2},  // R2
    {1'b1,3'd0,2'd1,32'hFFFFABCD, 3'd0,2'd0,32'h1122ABCD, 4'd3},  // R3
    {1'b1,3'd0,2'd2,32'hFFFFFF5A, 3'd0,2'd0,32'h1122AB5A, 4'd4},  // R4
    {1'b1,3'd0,2'd3,32'hFFFFFF77, 3'd0,2'd0,32'h1122775A, 4'd5},  // R5
    {1'b0,3'd0,2'd0,32'h0,        3'd0,2'd1,32'h0000775A, 4'd6},  // R6
    {1'b0,3'd0,2'd0,32'h0,        3'd0,2'd2,32'h0000005A, 4'd6},  // R6
    {1'b0,3'd0,2'd0,32'h0,        3'd0,2'd3,32'h00000077, 4'd6},  // R6
    {1'b1,3'd3,2'd3,32'h000000C3, 3'd3,2'd0,32'h0000C300, 4'd5},  // R5
    {1'b1,3'd5,2'd0,32'hDEADBEEF, 3'd5,2'd0,32'hDEADBEEF, 4'd2},  // R2
    {1'b1,3'd5,2'd3,32'h00000012, 3'd5,2'd0,32'hDEADBEEF, 4'd7},  // R7
    {1'b1,3'd5,2'd2,32'h00000001, 3'd5,2'd0,32'hDEADBE01, 4'd4},  // R4
    {1'b1,3'd7,2'd1,32'hAAAA1234, 3'd7,2'd0,32'h00001234, 4'd3},  // R3
    {1'b0,3'd0,2'd0,32'h0,        3'd0,2'd0,32'h1122775A, 4'd10}, // R10
    {1'b0,3'd0,2'd0,32'hFFFFFFFF, 3'd3,2'd0,32'h0000C300, 4'd10}  // R10
  };

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 8; i++) begin  // R1
      ra_idx = 3'(i); rb_idx = 3'(7 - i); #1;
      chk("R1", ra_data, 0); chk("R1", rb_data, 0);
    end
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      {wr_en, wr_idx, wr_view, wr_data, ra_idx, ra_view} = VEC[i][78:36];
      @(negedge clk);
      wr_en = 0;
      chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), ra_data, VEC[i][35:4]);
    end
    // R8: same-cycle read sees old value, new value after edge
    @(negedge clk);
    wr_en = 1; wr_idx = 1; wr_view = 0; wr_data = 32'h00000055; ra_idx = 1; ra_view = 0; #1;
    chk("R8 before edge", ra_data, 0);
    @(negedge clk); wr_en = 0;
    chk("R8 after edge", ra_data, 32'h55);
    // R7: error flags and zero read
    ra_idx = 6; ra_view = 3; rb_idx = 2; rb_view = 3; #1;
    chk("R7 ra_err", {31'b0, ra_err}, 1); chk("R7 ra_data", ra_data, 0);
    chk("R7 rb_err legal", {31'b0, rb_err}, 0);
    wr_en = 1; wr_idx = 4; wr_view = 3; #1;
    chk("R7 wr_err", {31'b0, wr_err}, 1);
    wr_idx = 3; #1;
    chk("R7 wr_err legal", {31'b0, wr_err}, 0);
    wr_en = 0;
    // R9: ports independent
    ra_idx = 5; ra_view = 1; rb_idx = 0; rb_view = 3; #1;
    chk("R9 port A", ra_data, 32'h0000BE01); chk("R9 port B", rb_data, 32'h77);
    // R1: reset again clears
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    ra_idx = 0; ra_view = 0; rb_idx = 5; rb_view = 0; #1;
    chk("R1 after reset", ra_data, 0); chk("R1 after reset", rb_data, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule